// File: doc/BRIEF.md
# High-Speed Handshake Reset Sequencer (Host Side)

This block runs the host end of a bus reset that may turn into a high-speed handshake. A one-cycle request starts the reset. The block then drives SE0 on the bus and watches the receiver line state for a K from the peripheral. It accepts the K only after the K has been present for a minimum run of cycles. When that qualified K ends, the block answers without delay. It issues a transmit command with a NOPID type and then sends K and J symbols in strict alternation. Every symbol has a fixed length, chosen as the middle of the legal 40 to 60 µs window.

A reset timer starts at the request and decides when the reset ends. Chirping stops only at the first symbol boundary that falls at or after the expiry of that timer. The transceiver operating mode then returns to normal and a high-speed flag is raised. If no qualified K is followed by its end in time, the bus stays in plain SE0 for the whole reset and the reset finishes at full speed.

States: IDLE (after reset), WAIT_K (SE0, no K), COUNT_K (SE0, K being timed), HOLD_K (SE0, qualified K still present), ISSUE_CMD (command strobe and first K cycle), CHIRP (symbol stream), DONE_HS and DONE_FS. Transitions: IDLE/DONE_* go to WAIT_K on a request. WAIT_K goes to COUNT_K on K. COUNT_K goes back to WAIT_K when the K drops early, and to HOLD_K when the K has lasted QUAL_CYC samples. HOLD_K goes to ISSUE_CMD when the K ends. ISSUE_CMD goes to CHIRP. CHIRP toggles at each boundary and goes to DONE_HS at the first boundary after reset expiry. WAIT_K, COUNT_K and HOLD_K go to DONE_FS on reset expiry, and that expiry takes priority over every other transition out of those states. Defaults for a 60 MHz clock: QUAL_CYC=150, SYM_CYC=3000, RESET_CYC=600000.

Top module: `host_chirp_responder`

## Requirements
- R1: After rst_n is released, every output is low (se0_drive, txcmd_stb, chirp_j, reset_done, hs_enabled) and txcmd_data and opmode read zero.
- R2: start_reset sampled high while idle or finished starts a reset, and se0_drive is high in the next cycle. start_reset sampled during a reset in progress changes nothing.
- R3: When no qualified K occurs, se0_drive is high for exactly RESET_CYC cycles. Then reset_done is set and hs_enabled, opmode and txcmd_stb stay low.
- R4: linestate 2'b10 (K) counts as a peripheral chirp only after QUAL_CYC consecutive samples during SE0. A shorter K is ignored, and watching continues for a later K.
- R5: In the cycle after the first non-K sample that follows a qualified K, se0_drive is low. In that same cycle txcmd_stb is high for one cycle with txcmd_data = 8'h40 (transmit, NOPID), chirp_j = 0 (K) and opmode = 2'b10.
- R6: The symbol stream starts with K and alternates K/J (chirp_j 0/1). Each symbol lasts exactly SYM_CYC cycles, and opmode = 2'b10 throughout.
- R7: Chirping ends at the first symbol boundary whose last cycle is at or after cycle RESET_CYC-1 from reset start. From the next cycle opmode = 2'b00, reset_done = 1 and hs_enabled = 1.
- R8: If the reset timer expires while a K is being timed, while a qualified K is still present, or in the very cycle the qualified K ends, no command is issued and the reset finishes as in R3.
- R9: linestate has no effect while symbols are being sent or after the reset has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (60 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_reset | input | 1 | Request to start a bus reset |
| linestate | input | 2 | Receiver line state; 2'b10 is K |
| se0_drive | output | 1 | Host drives SE0 on the bus |
| txcmd_stb | output | 1 | One-cycle transmit command strobe |
| txcmd_data | output | 8 | Transmit command byte, 8'h40 (NOPID) with the strobe, else 0 |
| chirp_j | output | 1 | Symbol select while chirping: 0 = K, 1 = J |
| opmode | output | 2 | Transceiver operating mode: 2'b10 while chirping, else 2'b00 |
| reset_done | output | 1 | Reset sequence finished |
| hs_enabled | output | 1 | Reset finished with high-speed handshake |

## Verification
Two events can land in the same cycle: the end of the peripheral K, which starts the response, and expiry of the reset timer, which closes the reset. The bench places the K so that it ends one cycle before expiry, in the expiry cycle itself, and while it is still held at expiry. A model computes the first transmit cycle and the closing symbol boundary, and every output is compared with that model in every cycle. Randomized runs also add early short K pulses and extra requests sent mid-reset.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_K,
        ST_COUNT_K,
        ST_HOLD_K,
        ST_ISSUE_CMD,
        ST_CHIRP,
        ST_DONE_HS,
        ST_DONE_FS
    } hcr_state_e;

    localparam logic [1:0] LS_K         = 2'b10;
    localparam logic [1:0] OPM_NORMAL   = 2'b00;
    localparam logic [1:0] OPM_RAW      = 2'b10;
    localparam logic [7:0] TXCMD_NOPID  = 8'h40;

endpackage

// File: rtl/hcr_line_decode.sv
module hcr_line_decode
    import hcr_pkg::*;
(
    input  logic [1:0] linestate,
    output logic       is_k
);

    // K on the bus during host SE0 means the peripheral is chirping
    assign is_k = (linestate == LS_K);

endmodule

// File: rtl/hcr_counter.sv
module hcr_counter #(
    parameter int LIMIT = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  en,
    output logic [((LIMIT > 1) ? $clog2(LIMIT) : 1)-1:0] cnt
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    // Saturating up-counter; clear wins over enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/host_chirp_responder.sv
module host_chirp_responder
    import hcr_pkg::*;
#(
    parameter int QUAL_CYC  = 150,
    parameter int SYM_CYC   = 3000,
    parameter int RESET_CYC = 600000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_reset,
    input  logic [1:0] linestate,
    output logic       se0_drive,
    output logic       txcmd_stb,
    output logic [7:0] txcmd_data,
    output logic       chirp_j,
    output logic [1:0] opmode,
    output logic       reset_done,
    output logic       hs_enabled
);

    localparam int SYM_LIM = (SYM_CYC > QUAL_CYC) ? SYM_CYC : QUAL_CYC;
    localparam int SYM_W   = (SYM_LIM > 1) ? $clog2(SYM_LIM) : 1;
    localparam int RST_W   = (RESET_CYC > 1) ? $clog2(RESET_CYC) : 1;
    localparam logic [SYM_W-1:0] QUAL_LAST = SYM_W'(QUAL_CYC - 1);
    localparam logic [SYM_W-1:0] SYM_LAST  = SYM_W'(SYM_CYC - 1);
    localparam logic [RST_W-1:0] RST_LAST  = RST_W'(RESET_CYC - 1);

    hcr_state_e       state_q, state_d;
    logic             sym_j_q, sym_j_d;
    logic             is_k;
    logic             rst_clr, rst_en, sym_clr, sym_en;
    logic [RST_W-1:0] rst_cnt;
    logic [SYM_W-1:0] sym_cnt;
    logic             rst_end;

    hcr_line_decode u_decode (
        .linestate (linestate),
        .is_k      (is_k)
    );

    // Reset duration: runs from the request, saturates at expiry
    hcr_counter #(.LIMIT(RESET_CYC)) u_rst_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_clr),
        .en    (rst_en),
        .cnt   (rst_cnt)
    );

    // Shared timer: K qualification, then symbol length
    hcr_counter #(.LIMIT(SYM_LIM)) u_sym_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sym_clr),
        .en    (sym_en),
        .cnt   (sym_cnt)
    );

    assign rst_end = (rst_cnt == RST_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sym_j_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sym_j_q <= sym_j_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d = state_q;
        sym_j_d = sym_j_q;
        rst_clr = 1'b0;
        rst_en  = 1'b0;
        sym_clr = 1'b0;
        sym_en  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE_HS, ST_DONE_FS: begin
                rst_clr = 1'b1;
                sym_clr = 1'b1;
                if (start_reset) begin
                    state_d = ST_WAIT_K;
                    sym_j_d = 1'b0;
                end
            end
            ST_WAIT_K: begin
                rst_en = 1'b1;
                if (rst_end) begin
                    state_d = ST_DONE_FS;
                end else if (is_k) begin
                    sym_en  = 1'b1;
                    state_d = ST_COUNT_K;
                end else begin
                    sym_clr = 1'b1;
                end
            end
            ST_COUNT_K: begin
                rst_en = 1'b1;
                if (rst_end) begin
                    state_d = ST_DONE_FS;
                end else if (!is_k) begin
                    sym_clr = 1'b1;
                    state_d = ST_WAIT_K;
                end else if (sym_cnt == QUAL_LAST) begin
                    sym_clr = 1'b1;
                    state_d = ST_HOLD_K;
                end else begin
                    sym_en = 1'b1;
                end
            end
            ST_HOLD_K: begin
                rst_en  = 1'b1;
                sym_clr = 1'b1;
                if (rst_end) begin
                    state_d = ST_DONE_FS;
                end else if (!is_k) begin
                    state_d = ST_ISSUE_CMD;
                    sym_j_d = 1'b0;
                end
            end
            ST_ISSUE_CMD: begin
                // counts as the first cycle of the first K symbol
                rst_en  = 1'b1;
                sym_en  = 1'b1;
                state_d = ST_CHIRP;
            end
            ST_CHIRP: begin
                rst_en = 1'b1;
                if (sym_cnt == SYM_LAST) begin
                    sym_clr = 1'b1;
                    if (rst_end) begin
                        state_d = ST_DONE_HS;
                    end else begin
                        sym_j_d = ~sym_j_q;
                    end
                end else begin
                    sym_en = 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        se0_drive  = 1'b0;
        txcmd_stb  = 1'b0;
        txcmd_data = 8'h00;
        chirp_j    = 1'b0;
        opmode     = OPM_NORMAL;
        reset_done = 1'b0;
        hs_enabled = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT_K, ST_COUNT_K, ST_HOLD_K: begin
                se0_drive = 1'b1;
            end
            ST_ISSUE_CMD: begin
                txcmd_stb  = 1'b1;
                txcmd_data = TXCMD_NOPID;
                opmode     = OPM_RAW;
                chirp_j    = sym_j_q;
            end
            ST_CHIRP: begin
                opmode  = OPM_RAW;
                chirp_j = sym_j_q;
            end
            ST_DONE_HS: begin
                reset_done = 1'b1;
                hs_enabled = 1'b1;
            end
            ST_DONE_FS: begin
                reset_done = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
    parameter int SYM_CYC = 3000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       se0_drive,
    input logic       txcmd_stb,
    input logic [7:0] txcmd_data,
    input logic       chirp_j,
    input logic [1:0] opmode,
    input logic       reset_done,
    input logic       hs_enabled
);

    localparam int RW = $clog2(SYM_CYC + 1) + 1;

    logic          tx, tx_q, j_q;
    logic [RW-1:0] run;

    assign tx = (opmode == 2'b10);

    // Length of the current symbol so far, up to the previous cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
            j_q  <= 1'b0;
            run  <= '0;
        end else begin
            tx_q <= tx;
            j_q  <= chirp_j;
            if (!tx) begin
                run <= '0;
            end else if (!tx_q || (chirp_j != j_q)) begin
                run <= RW'(1);
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    a_r5_cmd_code: assert property (@(posedge clk) disable iff (!rst_n)
        txcmd_stb |-> (txcmd_data == 8'h40) && !chirp_j && (opmode == 2'b10));

    a_r5_cmd_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
        txcmd_stb |-> $past(se0_drive));

    a_r5_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        txcmd_stb |=> !txcmd_stb);

    a_r6_sym_len: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q && (!tx || (chirp_j != j_q))) |-> (run == RW'(SYM_CYC)));

    a_r6_j_inside_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_j) |-> ($past(opmode) == 2'b10) && tx);

    a_r7_hs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hs_enabled |-> reset_done && (opmode == 2'b00) && !se0_drive);

    a_r3_se0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        se0_drive |-> (opmode == 2'b00) && !reset_done && !txcmd_stb);

endmodule

bind host_chirp_responder hcr_checker #(.SYM_CYC(SYM_CYC)) u_hcr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .se0_drive  (se0_drive),
    .txcmd_stb  (txcmd_stb),
    .txcmd_data (txcmd_data),
    .chirp_j    (chirp_j),
    .opmode     (opmode),
    .reset_done (reset_done),
    .hs_enabled (hs_enabled)
);

// File: tb/host_chirp_responder_bench.sv
module host_chirp_responder_bench;

    localparam int QUAL  = 8;
    localparam int SYM   = 20;
    localparam int RESET = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_reset = 1'b0;
    logic [1:0] linestate = 2'b01;
    logic       se0_drive, txcmd_stb, chirp_j, reset_done, hs_enabled;
    logic [7:0] txcmd_data;
    logic [1:0] opmode;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    host_chirp_responder #(
        .QUAL_CYC  (QUAL),
        .SYM_CYC   (SYM),
        .RESET_CYC (RESET)
    ) u_host_chirp_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_reset (start_reset),
        .linestate   (linestate),
        .se0_drive   (se0_drive),
        .txcmd_stb   (txcmd_stb),
        .txcmd_data  (txcmd_data),
        .chirp_j     (chirp_j),
        .opmode      (opmode),
        .reset_done  (reset_done),
        .hs_enabled  (hs_enabled)
    );

    function automatic logic [14:0] pack_out();
        return {se0_drive, txcmd_stb, txcmd_data, chirp_j, opmode, reset_done, hs_enabled};
    endfunction

    // Expected outputs in cycle i of a reset (cycle 0 = first SE0 cycle)
    function automatic logic [14:0] expect_vec(int i, bit chirp, int t0, int tend);
        logic       e_se0, e_stb, e_j, e_done, e_hs;
        logic [7:0] e_data;
        logic [1:0] e_opm;
        bit         in_tx;
        if (chirp) begin
            in_tx  = (i >= t0) && (i <= tend);
            e_se0  = (i < t0);
            e_stb  = (i == t0);
            e_data = (i == t0) ? 8'h40 : 8'h00;
            e_j    = in_tx && ((((i - t0) / SYM) % 2) == 1);
            e_opm  = in_tx ? 2'b10 : 2'b00;
            e_done = (i > tend);
            e_hs   = (i > tend);
        end else begin
            e_se0  = (i < RESET);
            e_stb  = 1'b0;
            e_data = 8'h00;
            e_j    = 1'b0;
            e_opm  = 2'b00;
            e_done = (i >= RESET);
            e_hs   = 1'b0;
        end
        return {e_se0, e_stb, e_data, e_j, e_opm, e_done, e_hs};
    endfunction

    task automatic check(string tag, int cyc, logic [14:0] act, logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // s/slen: early short K (s<0: none); a/l: main K (a<0: none);
    // mid: cycle of an extra start_reset pulse (-1: none)
    task automatic run_case(int s, int slen, int a, int l, int mid, string ftag);
        bit    chirp;
        int    t0, nsym, tend, total;
        string tag;
        chirp = (a >= 0) && (l >= QUAL) && (a + l <= RESET - 2);
        t0    = a + l + 1;
        nsym  = chirp ? (RESET - t0 + SYM - 1) / SYM : 0;
        tend  = t0 + nsym * SYM - 1;
        total = chirp ? tend + 6 : RESET + 6;
        @(negedge clk);
        start_reset = 1'b1;
        linestate   = 2'b01;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (i == 0 || (mid >= 0 && i > mid && i <= mid + 2))
                tag = "R2";
            else if (!chirp)
                tag = ftag;
            else if (i < t0)
                tag = "R4";
            else if (i == t0)
                tag = "R5";
            else if (i <= tend)
                tag = "R6,R9";
            else
                tag = "R7,R9";
            check(tag, i, pack_out(), expect_vec(i, chirp, t0, tend));
            start_reset = (i == mid);
            if (s >= 0 && i >= s && i < s + slen)
                linestate = 2'b10;
            else if (a >= 0 && i >= a && i < a + l)
                linestate = 2'b10;
            else if ((chirp && i >= t0) || (!chirp && i >= RESET))
                linestate = 2'($urandom % 4);   // R9: any value, K included
            else
                linestate = ($urandom % 2 == 1) ? 2'b01 : 2'b00;
        end
        start_reset = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1b3d));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", -1, pack_out(), 15'h0000);
        linestate = 2'b10;
        repeat (3) @(negedge clk);
        check("R1", -1, pack_out(), 15'h0000);

        // directed: short K of QUAL-1 ignored, then K of exactly QUAL
        run_case(5, QUAL - 1, 5 + QUAL, QUAL, -1, "R4");
        // directed: no K at all, plain SE0 reset
        run_case(-1, 0, -1, 0, -1, "R3");
        // directed: lone short K only
        run_case(-1, 0, 30, QUAL - 1, -1, "R4");
        // directed: K still held at expiry
        run_case(-1, 0, RESET - QUAL - 20, 100, -1, "R8");
        // directed: K ends one cycle before expiry -> one symbol
        run_case(-1, 0, RESET - 2 - (QUAL + 3), QUAL + 3, -1, "R4");
        // directed: K end coincides with expiry
        run_case(-1, 0, RESET - 1 - (QUAL + 3), QUAL + 3, -1, "R8");
        // directed: K starts too late to qualify
        run_case(-1, 0, RESET - QUAL, QUAL + 10, -1, "R8");
        // directed: extra request during symbols
        run_case(-1, 0, 10, QUAL, 300, "R2");

        for (int n = 0; n < 7; n++) begin
            int s, slen, a, l, mid;
            if ($urandom % 2 == 1) begin
                s    = int'($urandom % 20);
                slen = 1 + int'($urandom % (QUAL - 1));
                a    = s + slen + 1 + int'($urandom % 10);
            end else begin
                s    = -1;
                slen = 0;
                a    = int'($urandom % 30);
            end
            l   = QUAL + int'($urandom % 50);
            mid = ($urandom % 3 == 0) ? 1 + int'($urandom % 300) : -1;
            run_case(s, slen, a, l, mid, "R4");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule